// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block tallies coins arriving through a single slot that takes five-cent and ten-cent pieces. Each coin shows up as a one-cycle pulse on its own input. When the running credit reaches fifteen cents, the block raises a release signal for the dispensing mechanism. An overpayment is absorbed and no change is returned. The block then holds the release condition until it is reset.

Credit is kept in four states held in a two-bit binary code: 0, 5, 10 and 15 cents. The code is visible on `credit_o`. A pulse on both coin inputs in the same cycle is illegal. It leaves the credit unchanged and raises a one-cycle fault pulse.

A parameter selects one of two release stages:
- **Decoded variant:** decodes the release signal from the credit register.
- **Registered variant:** builds the release signal from the next-credit logic into its own flop. This puts no gates between the flop and the pin.

Both variants assert release after the same clock edge.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A rising clock edge sampled with `rst_n` low sets `credit_o` to 2'b00, `release_o` to 0 and `fault_o` to 0 for the following cycle.
- R2: A nickel pulse moves the credit one step: 2'b00 to 2'b01, 2'b01 to 2'b10, and 2'b10 to 2'b11. Here 2'b00 is 0 cents, 2'b01 is 5, 2'b10 is 10 and 2'b11 is 15.
- R3: A dime pulse moves 2'b00 to 2'b10, and moves both 2'b01 and 2'b10 to 2'b11. The excess is dropped.
- R4: In a cycle with no coin pulse and reset high, the credit keeps its value.
- R5: `release_o` is 1 exactly while `credit_o` is 2'b11. It rises in the cycle right after the edge that sampled the completing coin, with either setting of `RETIMED`.
- R6: Once the credit is 2'b11, further coins leave it at 2'b11 and `release_o` stays 1 until a reset.
- R7: Nickel and dime high in the same cycle leave the credit unchanged and drive `fault_o` to 1 for exactly the next cycle.
- R8: `fault_o` is 0 in every cycle that does not follow a nickel-and-dime collision.
- R9: Reset takes priority over coin pulses sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| nickel_i | input | 1 | One-cycle pulse per five-cent coin |
| dime_i | input | 1 | One-cycle pulse per ten-cent coin |
| credit_o | output | 2 | Present credit code (00, 01, 10, 11 for 0, 5, 10, 15 cents) |
| release_o | output | 1 | High while fifteen cents or more has been paid |
| fault_o | output | 1 | One-cycle pulse after both coin inputs were high together |

## Verification
The assertions take the coin inputs and reset to be known values that are steady around each rising edge. They do not rely on coins being isolated single-cycle pulses, so a long pulse is simply counted once per cycle. The stimulus changes every input on the falling edge and mostly gives single pulses separated by idle cycles. It also deliberately drives the collision and reset-with-coin cases that the properties cover. Both release variants run side by side on the same inputs, so a difference in their timing shows up directly.

// File: rtl/vend_pkg.sv
// Package: shared credit encoding for the vending controller.
// Assumes a two-bit binary code whose top value is the paid state.
package vend_pkg;
    localparam int CREDIT_W = 2;
    localparam int SUM_W    = CREDIT_W + 1;

    typedef enum logic [CREDIT_W-1:0] {
        CR_0  = 2'b00,
        CR_5  = 2'b01,
        CR_10 = 2'b10,
        CR_15 = 2'b11
    } credit_e;

    localparam logic [SUM_W-1:0] STEP_NICKEL = SUM_W'(1);
    localparam logic [SUM_W-1:0] STEP_DIME   = SUM_W'(2);
    localparam logic [SUM_W-1:0] SUM_LIMIT   = SUM_W'(CR_15);
endpackage

// File: rtl/vend_next_credit.sv
// Module: combinational next-credit function.
// Reset gates the result to zero credit. A collision of both coins, or the
// paid state, holds the present value. Otherwise the coin weight is added
// and the sum saturates at the paid code.
// Assumes: run_i is the active-high form of the synchronous reset.
module vend_next_credit
    import vend_pkg::*;
(
    input  credit_e cur_i,
    input  logic    run_i,
    input  logic    nickel_i,
    input  logic    dime_i,
    output credit_e nxt_o,
    output logic    clash_o
);
    logic [SUM_W-1:0] weight;
    logic [SUM_W-1:0] sum;

    // Purpose: flag the illegal simultaneous-coin case.
    always_comb clash_o = nickel_i & dime_i;

    // Purpose: weight of the coin seen this cycle.
    always_comb begin
        weight = '0;
        if (nickel_i)    weight = STEP_NICKEL;
        else if (dime_i) weight = STEP_DIME;
    end

    // Purpose: saturating credit update with reset gating.
    always_comb begin
        sum = {1'b0, cur_i} + weight;
        if (!run_i)
            nxt_o = CR_0;
        else if (clash_o || cur_i == CR_15)
            nxt_o = cur_i;
        else if (sum >= SUM_LIMIT)
            nxt_o = CR_15;
        else
            nxt_o = credit_e'(sum[CREDIT_W-1:0]);
    end
endmodule

// File: rtl/vend_credit_reg.sv
// Module: credit state flops and the registered collision fault.
// Assumes the next-credit input already carries the reset gating.
// The fault flop is cleared by reset directly.
module vend_credit_reg
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  credit_e nxt_i,
    input  logic    clash_i,
    output credit_e cur_o,
    output logic    fault_o
);
    // Purpose: hold the present credit.
    always_ff @(posedge clk) cur_o <= nxt_i;

    // Purpose: one-cycle fault pulse after a coin collision.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_o <= 1'b0;
        else        fault_o <= clash_i;
    end
endmodule

// File: rtl/vend_release_reg.sv
// Module: retimed release flop.
// Loads the paid decode of the next credit, so the pin is driven straight
// from a flop and changes at the same edge as the credit register.
// Assumes a synchronous active-low reset.
module vend_release_reg
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  credit_e nxt_i,
    output logic    release_o
);
    // Purpose: register the paid condition one step ahead.
    always_ff @(posedge clk) begin
        if (!rst_n) release_o <= 1'b0;
        else        release_o <= (nxt_i == CR_15);
    end
endmodule

// File: rtl/coin_vend_ctrl.sv
// Module: top of the coin-accumulating vending controller.
// RETIMED=1 drives release from its own flop fed by the next-credit logic.
// RETIMED=0 decodes release from the credit register.
// Assumes: coins arrive as pulses synchronous to clk, and reset is
// synchronous and active low.
module coin_vend_ctrl
    import vend_pkg::*;
#(
    parameter bit RETIMED = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nickel_i,
    input  logic                dime_i,
    output logic [CREDIT_W-1:0] credit_o,
    output logic                release_o,
    output logic                fault_o
);
    credit_e cur;
    credit_e nxt;
    logic    clash;

    vend_next_credit u_next (
        .cur_i    (cur),
        .run_i    (rst_n),
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .nxt_o    (nxt),
        .clash_o  (clash)
    );

    vend_credit_reg u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .nxt_i   (nxt),
        .clash_i (clash),
        .cur_o   (cur),
        .fault_o (fault_o)
    );

    generate
        if (RETIMED) begin : g_retimed
            vend_release_reg u_rel (
                .clk       (clk),
                .rst_n     (rst_n),
                .nxt_i     (nxt),
                .release_o (release_o)
            );
        end else begin : g_decoded
            // Purpose: release decoded from the present credit.
            assign release_o = (cur == CR_15);
        end
    endgenerate

    // Purpose: expose the credit code.
    assign credit_o = cur;
endmodule

// File: rtl/vend_ctrl_checker.sv
// Module: temporal checks on the vending controller's ports.
// Attached to every instance of the top through a bind.
module vend_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       nick,
    input logic       dime,
    input logic [1:0] credit,
    input logic       rel,
    input logic       fault
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (credit == 2'b00 && !rel && !fault)); // R1
    AST_NICKEL_STEP: assert property (@(posedge clk) disable iff (!rst_n) (nick && !dime && credit != 2'b11) |=> credit == 2'($past(credit) + 2'd1)); // R2
    AST_DIME_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (dime && !nick && credit == 2'b00) |=> credit == 2'b10); // R3
    AST_DIME_TO_PAID: assert property (@(posedge clk) disable iff (!rst_n) (dime && !nick && credit != 2'b00) |=> credit == 2'b11); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!nick && !dime) |=> $stable(credit)); // R4
    AST_RELEASE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) rel == (credit == 2'b11)); // R5
    AST_PAID_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (credit == 2'b11) |=> (credit == 2'b11 && rel)); // R6
    AST_CLASH_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (nick && dime) |=> (fault && $stable(credit))); // R7
    AST_NO_SPURIOUS_FAULT: assert property (@(posedge clk) disable iff (!rst_n) !(nick && dime) |=> !fault); // R8
endmodule

bind coin_vend_ctrl vend_ctrl_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .nick   (nickel_i),
    .dime   (dime_i),
    .credit (credit_o),
    .rel    (release_o),
    .fault  (fault_o)
);

// File: tb/sim_coin_vend_ctrl.sv
// Bench: the driver task predicts each cycle's outputs into a queue, and a
// monitor pops and compares them against both release variants.
module sim_coin_vend_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nick = 1'b0;
    logic dime = 1'b0;
    logic [1:0] cr0, cr1;
    logic rel0, rel1, flt0, flt1;

    always #5 clk = ~clk;

    coin_vend_ctrl #(.RETIMED(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .nickel_i(nick), .dime_i(dime),
        .credit_o(cr0), .release_o(rel0), .fault_o(flt0));

    coin_vend_ctrl #(.RETIMED(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .nickel_i(nick), .dime_i(dime),
        .credit_o(cr1), .release_o(rel1), .fault_o(flt1));

    typedef struct packed {
        logic [1:0] cr;
        logic       rel;
        logic       flt;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    logic [1:0] m_cr = 2'b00;
    bit    done = 1'b0;

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the predicted outputs.
    task automatic step(input logic r, input logic n, input logic d, input string tag);
        exp_t e;
        logic [2:0] s;
        @(negedge clk);
        rst_n = r; nick = n; dime = d;
        if (!r) m_cr = 2'b00;
        else if (!(n && d) && m_cr != 2'b11) begin
            s = {1'b0, m_cr} + (n ? 3'd1 : 3'd0) + (d ? 3'd2 : 3'd0);
            m_cr = (s > 3'd3) ? 2'b11 : s[1:0];
        end
        e.cr  = m_cr;
        e.rel = (m_cr == 2'b11);
        e.flt = r & n & d;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare one item just after each rising edge.
    always begin
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            cmp(t, "u0 credit",  int'(cr0),  int'(e.cr));
            cmp(t, "u0 release", int'(rel0), int'(e.rel));
            cmp(t, "u0 fault",   int'(flt0), int'(e.flt));
            cmp(t, "u1 credit",  int'(cr1),  int'(e.cr));
            cmp(t, "u1 release", int'(rel1), int'(e.rel));
            cmp(t, "u1 fault",   int'(flt1), int'(e.flt));
        end
    end

    initial begin
        // R1: reset state
        step(0, 0, 0, "R1");
        step(0, 0, 0, "R1");
        // R9: reset wins over coins
        step(0, 1, 0, "R9");
        step(0, 0, 1, "R9");
        // R2 / R4 / R5: three nickels with idle gaps
        step(1, 1, 0, "R2");
        step(1, 0, 0, "R4");
        step(1, 1, 0, "R2");
        step(1, 0, 0, "R4");
        step(1, 0, 0, "R4");
        step(1, 1, 0, "R5");
        // R6: paid state ignores coins
        step(1, 1, 0, "R6");
        step(1, 0, 1, "R6");
        step(1, 0, 0, "R6");
        step(1, 1, 1, "R6");
        // R9: reset while paid with a dime present
        step(0, 0, 1, "R9");
        // R3: dime from 0 then from 10
        step(1, 0, 1, "R3");
        step(1, 0, 0, "R4");
        step(1, 0, 1, "R3");
        step(0, 0, 0, "R1");
        // R3: dime from 5
        step(1, 1, 0, "R2");
        step(1, 0, 1, "R3");
        step(0, 0, 0, "R1");
        // R3: nickel, nickel, dime
        step(1, 1, 0, "R2");
        step(1, 1, 0, "R2");
        step(1, 0, 1, "R3");
        step(0, 0, 0, "R1");
        // R7 / R8: collision holds credit, fault pulses once
        step(1, 1, 0, "R2");
        step(1, 1, 1, "R7");
        step(1, 0, 0, "R8");
        step(1, 1, 1, "R7");
        step(1, 1, 1, "R7");
        step(1, 1, 0, "R8");
        step(1, 1, 0, "R5");
        step(1, 0, 0, "R8");
        step(1, 0, 0, "R6");
        repeat (3) @(posedge clk);
        #2;
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R5 queue actual=%0d expected=%0d", exp_q.size(), 0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule